// File: doc/BRIEF.md
# Programmable Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt requests, ranks them by a fixed priority and raises a single interrupt line toward a processor. Software reaches it through two byte-wide addresses: a control address and an auxiliary address. A short configuration sequence sets it up. It starts with a control write that has bit 4 set, and a chain of auxiliary writes follows it. After that, auxiliary writes load the interrupt mask and control writes carry run-time commands.

When the processor acknowledges an interrupt, the block moves the winning request into its in-service set. It then answers one cycle later with an 8-bit vector: the programmed base with its low three bits replaced by the input number. A non-specific end-of-interrupt command retires the highest-priority service in progress. Several controllers can be chained. A master knows which of its inputs carry a slave, and on those inputs it emits the input number as a cascade code instead of a vector. A slave only answers an acknowledge whose cascade selection matches its programmed identity. Each input can be edge or level triggered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the block is unconfigured: `int_out` and `vec_vld` are 0, and a read of the auxiliary address returns the mask value 0xFF. Until the configuration sequence ends, `int_out` stays 0, `inta` is ignored and auxiliary writes do not change the mask.
- R2: A control write with bit 4 set starts configuration. Bit 0 of that word asks for a mode word and bit 3 selects level triggering for all inputs. The next auxiliary writes are taken in order as the vector base, the cascade word and, only if it was asked for, the mode word. Only the auxiliary writes after that load the mask.
- R3: A mask bit of 1 blocks its input from raising `int_out`. A masked request stays visible in the request register.
- R4: An edge-triggered input sets its request bit on a rising edge. The bit stays set after the input falls and clears only when that request is acknowledged.
- R5: An input is level triggered when configuration bit 3 was set or its `level_sel` bit is 1. Its request bit then equals the input one clock earlier.
- R6: Input 0 has the highest priority. `int_out` is 1 only when an unmasked request exists and no in-service bit of equal or higher priority is set.
- R7: An `inta` pulse taken while `int_out` is 1 sets the winner's in-service bit and clears its edge request. On the next cycle `vec_vld` is 1 and `vec_out` = {base[7:3], input number}.
- R8: An `inta` pulse taken while `int_out` is 0 yields `vec_out` = {base[7:3], 3'b111} with `vec_vld` 1 and does not change the in-service register.
- R9: A control write of 0x20 clears the highest-priority set bit of the in-service register.
- R10: After configuration, control-address reads return the request register. A control write with bit 4 clear and bit 3 set sets the read source: low bits 3 select the in-service register, 2 selects the request register, and other values keep the current choice.
- R11: On a master (`slave_mode` 0), an acknowledge whose winner has its bit set in the cascade word drives `casc_act` 1 and `casc_code` = input number on the next cycle, with `vec_vld` 0.
- R12: On a slave (`slave_mode` 1), `inta` has effect only when `casc_sel_in` equals the low three bits of the cascade word. Otherwise nothing is set and no vector appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr_aux | input | 1 | Address select: 0 control, 1 auxiliary (reads and writes) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected address |
| irq_in | input | 8 | Interrupt request inputs |
| level_sel | input | 8 | Per-input level trigger select |
| slave_mode | input | 1 | 1 when this controller is a slave |
| casc_sel_in | input | 3 | Cascade selection seen by a slave |
| inta | input | 1 | Acknowledge pulse, one cycle |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector returned after an acknowledge |
| vec_vld | output | 1 | `vec_out` is valid this cycle |
| casc_code | output | 3 | Input number of the slave that must answer |
| casc_act | output | 1 | `casc_code` is valid this cycle |

## Verification
The assertions assume that `inta` is a single-cycle pulse and that a configuration start does not coincide with an acknowledge. They also assume that `slave_mode` and `level_sel` do not change while a request is latched. The stimulus drives every input on the falling edge and holds each operation to one cycle. It never places an end-of-interrupt, an acknowledge and an input edge on the same clock. It also changes the trigger selection only while the inputs are low.

// File: rtl/irq_ctrl_pkg.sv
// Shared types and constants for the priority interrupt controller.
// Assumes a byte-wide register interface.
package irq_ctrl_pkg;
    typedef enum logic [2:0] {
        CFG_BLANK,
        CFG_WANT_BASE,
        CFG_WANT_CASC,
        CFG_WANT_MODE,
        CFG_RUN
    } cfg_state_t;

    localparam int CTL_INIT_BIT  = 4;
    localparam int CTL_CMD3_BIT  = 3;
    localparam int INIT_WANT4_BIT = 0;
    localparam int INIT_LEVEL_BIT = 3;
    localparam logic [7:0] EOI_CODE = 8'h20;
    localparam logic [1:0] RB_ISR = 2'b11;
    localparam logic [1:0] RB_IRR = 2'b10;
endpackage

// File: rtl/irq_cfg_seq.sv
// Configuration sequencer: decodes control/auxiliary writes into the
// configuration chain (base, cascade word, optional mode word), mask
// loads, end-of-interrupt and readback-select commands.
// Assumes one write per strobe cycle.
module irq_cfg_seq
    import irq_ctrl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_aux,
    input  logic [DW-1:0] wr_data,
    output logic          cfg_done,
    output logic          init_start,
    output logic          mask_load,
    output logic          eoi_cmd,
    output logic [DW-1:0] base_q,
    output logic [DW-1:0] casc_q,
    output logic          level_all_q,
    output logic          rd_isr_q
);
    cfg_state_t state_q;
    logic       want4_q;
    logic       ctl_wr;
    logic       aux_wr;

    // Decode write targets and single-cycle commands.
    always_comb begin
        ctl_wr     = wr_en && !wr_aux;
        aux_wr     = wr_en && wr_aux;
        cfg_done   = (state_q == CFG_RUN);
        init_start = ctl_wr && wr_data[CTL_INIT_BIT];
        mask_load  = aux_wr && cfg_done;
        eoi_cmd    = ctl_wr && cfg_done && (wr_data == DW'(EOI_CODE));
    end

    // Walk the configuration chain and hold the readback source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CFG_BLANK;
            want4_q     <= 1'b0;
            level_all_q <= 1'b0;
            base_q      <= '0;
            casc_q      <= '0;
            rd_isr_q    <= 1'b0;
        end else if (init_start) begin
            state_q     <= CFG_WANT_BASE;
            want4_q     <= wr_data[INIT_WANT4_BIT];
            level_all_q <= wr_data[INIT_LEVEL_BIT];
            rd_isr_q    <= 1'b0;
        end else if (aux_wr) begin
            case (state_q)
                CFG_WANT_BASE: begin
                    base_q  <= wr_data;
                    state_q <= CFG_WANT_CASC;
                end
                CFG_WANT_CASC: begin
                    casc_q  <= wr_data;
                    state_q <= want4_q ? CFG_WANT_MODE : CFG_RUN;
                end
                CFG_WANT_MODE: state_q <= CFG_RUN;
                default: ;
            endcase
        end else if (ctl_wr && cfg_done && wr_data[CTL_CMD3_BIT]) begin
            if (wr_data[1:0] == RB_ISR)
                rd_isr_q <= 1'b1;
            else if (wr_data[1:0] == RB_IRR)
                rd_isr_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_req_bank.sv
// Request register bank: one cell per input. An edge cell latches on a
// rising input and clears on acknowledge; a level cell follows the input.
// Assumes the inputs are already synchronous to clk.
module irq_req_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] level_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] irr_q
);
    for (genvar g = 0; g < N; g++) begin : g_cell
        logic prev_q;
        logic req_q;

        // Track the input history and update this request bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                req_q  <= 1'b0;
            end else begin
                prev_q <= irq_in[g];
                if (level_mask[g])
                    req_q <= irq_in[g];
                else if (irq_in[g] && !prev_q)
                    req_q <= 1'b1;
                else if (clr_mask[g])
                    req_q <= 1'b0;
            end
        end

        assign irr_q[g] = req_q;
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: finds the lowest-numbered set bit.
// Assumes bit 0 is the highest priority.
module irq_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from lowest to highest priority so the last hit wins.
    always_comb begin
        any = |vec;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (vec[k])
                idx = IW'(k);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the priority interrupt controller: mask and in-service state,
// nesting decision, acknowledge handling with vector or cascade reply.
// Assumes NIN equals DW (one mask bit per data bit) and one-cycle inta.
module prio_irq_ctrl #(
    parameter int NIN = 8,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           addr_aux,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    input  logic [NIN-1:0] irq_in,
    input  logic [NIN-1:0] level_sel,
    input  logic           slave_mode,
    input  logic [2:0]     casc_sel_in,
    input  logic           inta,
    output logic           int_out,
    output logic [DW-1:0]  vec_out,
    output logic           vec_vld,
    output logic [2:0]     casc_code,
    output logic           casc_act
);
    localparam int IW = $clog2(NIN);

    logic           cfg_done, init_start, mask_load, eoi_cmd;
    logic [DW-1:0]  base_q, casc_q;
    logic           level_all_q, rd_isr_q;
    logic [NIN-1:0] irr_q, imr_q, isr_q, cand;
    logic [NIN-1:0] clr_mask, set_mask, eoi_mask;
    logic           cand_any, isr_any;
    logic [IW-1:0]  win_idx, isr_idx;
    logic           ack_ok, ack_take, ack_spur, to_slave;
    logic [DW-1:0]  vec_q;
    logic           vec_vld_q, casc_act_q;
    logic [2:0]     casc_code_q;

    irq_cfg_seq #(.DW(DW)) seq_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_aux(addr_aux),
        .wr_data(wr_data), .cfg_done(cfg_done), .init_start(init_start),
        .mask_load(mask_load), .eoi_cmd(eoi_cmd), .base_q(base_q),
        .casc_q(casc_q), .level_all_q(level_all_q), .rd_isr_q(rd_isr_q)
    );

    irq_req_bank #(.N(NIN)) req_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .level_mask(level_sel | {NIN{level_all_q}}),
        .clr_mask(clr_mask), .irr_q(irr_q)
    );

    irq_prio_pick #(.N(NIN), .IW(IW)) pick_req_i (
        .vec(cand), .any(cand_any), .idx(win_idx)
    );

    irq_prio_pick #(.N(NIN), .IW(IW)) pick_isr_i (
        .vec(isr_q), .any(isr_any), .idx(isr_idx)
    );

    // Nesting decision and acknowledge qualification.
    always_comb begin
        cand     = irr_q & ~imr_q;
        int_out  = cfg_done && cand_any && (!isr_any || (win_idx < isr_idx));
        ack_ok   = inta && cfg_done &&
                   (!slave_mode || (casc_sel_in == casc_q[2:0]));
        ack_take = ack_ok && int_out;
        ack_spur = ack_ok && !int_out;
        to_slave = !slave_mode && casc_q[win_idx];
        set_mask = ack_take ? (NIN'(1) << win_idx) : '0;
        clr_mask = set_mask;
        eoi_mask = (eoi_cmd && isr_any) ? (NIN'(1) << isr_idx) : '0;
    end

    // Mask register: all masked on reset and on a configuration start.
    always_ff @(posedge clk) begin
        if (!rst_n || init_start)
            imr_q <= '1;
        else if (mask_load)
            imr_q <= wr_data[NIN-1:0];
    end

    // In-service register: set on acknowledge, retire on end-of-interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || init_start)
            isr_q <= '0;
        else
            isr_q <= (isr_q | set_mask) & ~eoi_mask;
    end

    // Acknowledge reply: vector or cascade code, valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q       <= '0;
            vec_vld_q   <= 1'b0;
            casc_act_q  <= 1'b0;
            casc_code_q <= '0;
        end else begin
            vec_vld_q  <= (ack_take && !to_slave) || ack_spur;
            casc_act_q <= ack_take && to_slave;
            if (ack_take)
                vec_q <= {base_q[DW-1:IW], win_idx};
            else if (ack_spur)
                vec_q <= {base_q[DW-1:IW], {IW{1'b1}}};
            if (ack_take && to_slave)
                casc_code_q <= 3'(win_idx);
        end
    end

    // Readback: mask on the auxiliary address, IRR or ISR on control.
    always_comb begin
        if (addr_aux)
            rd_data = DW'(imr_q);
        else if (rd_isr_q)
            rd_data = DW'(isr_q);
        else
            rd_data = DW'(irr_q);
    end

    assign vec_out   = vec_q;
    assign vec_vld   = vec_vld_q;
    assign casc_code = casc_code_q;
    assign casc_act  = casc_act_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
// Property checker for prio_irq_ctrl, attached by bind below.
// Assumes inta is a one-cycle pulse that never meets a configuration start.
module irq_ctrl_chk #(
    parameter int NIN = 8,
    parameter int IW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_done,
    input logic           int_out,
    input logic [NIN-1:0] irr_q,
    input logic [NIN-1:0] imr_q,
    input logic [NIN-1:0] isr_q,
    input logic           isr_any,
    input logic           ack_take,
    input logic           ack_spur,
    input logic           eoi_cmd,
    input logic           init_start,
    input logic [IW-1:0]  win_idx,
    input logic           vec_vld,
    input logic [IW-1:0]  vec_low,
    input logic           casc_act
);
    assert_quiet_unconfigured_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !int_out);

    assert_pending_unmasked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr_q & ~imr_q) != '0));

    assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !init_start) |=> isr_q[$past(win_idx)]);

    assert_spurious_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_spur |=> (vec_vld && (vec_low == {IW{1'b1}})));

    assert_eoi_drops_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_cmd && isr_any && !ack_take) |=>
        ($countones(isr_q) == $countones($past(isr_q)) - 1));

    assert_single_responder_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_vld && casc_act));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NIN(NIN), .IW(IW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .int_out(int_out),
    .irr_q(irr_q), .imr_q(imr_q), .isr_q(isr_q), .isr_any(isr_any),
    .ack_take(ack_take), .ack_spur(ack_spur), .eoi_cmd(eoi_cmd),
    .init_start(init_start), .win_idx(win_idx), .vec_vld(vec_vld),
    .vec_low(vec_out[IW-1:0]), .casc_act(casc_act)
);

// File: tb/prio_irq_ctrl_tb.sv
// Bench for prio_irq_ctrl: directed corner cases plus seeded random traffic
// checked against a bench-side model of the request and service registers.
module prio_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr_aux = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [7:0] irq_in = '0;
    logic [7:0] level_sel = '0;
    logic       slave_mode = 1'b0;
    logic [2:0] casc_sel_in = '0;
    logic       inta = 1'b0;
    logic       int_out;
    logic [7:0] vec_out;
    logic       vec_vld;
    logic [2:0] casc_code;
    logic       casc_act;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr_aux(addr_aux),
        .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in),
        .level_sel(level_sel), .slave_mode(slave_mode),
        .casc_sel_in(casc_sel_in), .inta(inta), .int_out(int_out),
        .vec_out(vec_out), .vec_vld(vec_vld), .casc_code(casc_code),
        .casc_act(casc_act)
    );

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(bit aux, logic [7:0] d);
        wr_en = 1'b1; addr_aux = aux; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; addr_aux = 1'b0;
    endtask

    task automatic rd(bit aux, output logic [7:0] d);
        addr_aux = aux;
        #1 d = rd_data;
        addr_aux = 1'b0;
    endtask

    task automatic pulse_irq(int i);
        irq_in[i] = 1'b1;
        @(negedge clk);
        irq_in[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack();
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
    endtask

    function automatic int lowest(logic [7:0] v);
        for (int k = 0; k < 8; k++) if (v[k]) return k;
        return 8;
    endfunction

    function automatic bit exp_int(logic [7:0] irr, logic [7:0] imr, logic [7:0] isr);
        logic [7:0] c = irr & ~imr;
        return (c != 0) && (lowest(c) < lowest(isr));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] irr_m, imr_m, isr_m, msk;
        int r, i, w;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();

        // R1: reset and unconfigured behaviour
        chk("R1 int_out after reset", int'(int_out), 0);
        chk("R1 vec_vld after reset", int'(vec_vld), 0);
        rd(1, d); chk("R1 mask reset value", d, 8'hFF);
        pulse_irq(0);
        chk("R1 int_out unconfigured", int'(int_out), 0);
        wr(1, 8'h00);
        rd(1, d); chk("R1 aux write ignored unconfigured", d, 8'hFF);
        do_reset();

        // R2: master configuration with mode word
        wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h01);
        rd(1, d); chk("R2 mode word not taken as mask", d, 8'hFF);
        wr(1, 8'h00);
        rd(1, d); chk("R2 mask loaded after chain", d, 8'h00);
        rd(0, d); chk("R10 default readback is IRR", d, 8'h00);

        // R4/R7: edge latch and acknowledge
        pulse_irq(5);
        chk("R4 edge request held", int'(int_out), 1);
        rd(0, d); chk("R4 IRR after falling input", d, 8'h20);
        ack();
        chk("R7 vector valid", int'(vec_vld), 1);
        chk("R7 vector value", vec_out, 8'h45);
        wr(0, 8'h0B);
        rd(0, d); chk("R10 ISR readback", d, 8'h20);
        chk("R7 int_out after ack", int'(int_out), 0);
        wr(0, 8'h0A);
        rd(0, d); chk("R7 edge request cleared by ack", d, 8'h00);

        // R6/R9: nesting and end-of-interrupt order
        pulse_irq(6);
        chk("R6 lower priority blocked", int'(int_out), 0);
        pulse_irq(3);
        chk("R6 higher priority nests", int'(int_out), 1);
        ack();
        chk("R7 nested vector", vec_out, 8'h43);
        wr(0, 8'h0B);
        rd(0, d); chk("R7 ISR two bits", d, 8'h28);
        wr(0, 8'h01);
        rd(0, d); chk("R10 other select keeps ISR", d, 8'h28);
        wr(0, 8'h20);
        rd(0, d); chk("R9 EOI clears highest", d, 8'h20);
        chk("R6 equal-or-higher in service blocks", int'(int_out), 0);
        wr(0, 8'h20);
        rd(0, d); chk("R9 EOI clears last", d, 8'h00);
        chk("R6 pending released", int'(int_out), 1);
        ack();
        chk("R7 vector input 6", vec_out, 8'h46);
        wr(0, 8'h20);
        wr(0, 8'h0A);

        // R3: masking
        wr(1, 8'h02);
        pulse_irq(1);
        chk("R3 masked no interrupt", int'(int_out), 0);
        rd(0, d); chk("R3 masked request visible", d, 8'h02);
        wr(1, 8'h00);
        chk("R3 unmask raises", int'(int_out), 1);
        ack();
        chk("R3 vector after unmask", vec_out, 8'h41);
        wr(0, 8'h20);

        // R11: master cascade reply
        pulse_irq(2);
        chk("R11 slave input raises", int'(int_out), 1);
        ack();
        chk("R11 casc_act", int'(casc_act), 1);
        chk("R11 casc_code", casc_code, 2);
        chk("R11 no vector", int'(vec_vld), 0);
        wr(0, 8'h20);

        // R8: spurious acknowledge
        ack();
        chk("R8 spurious valid", int'(vec_vld), 1);
        chk("R8 spurious vector", vec_out, 8'h47);
        wr(0, 8'h0B);
        rd(0, d); chk("R8 ISR unchanged", d, 8'h00);
        wr(0, 8'h0A);

        // R5: per-input level trigger
        level_sel = 8'h10;
        irq_in[4] = 1'b1; @(negedge clk);
        rd(0, d); chk("R5 level request set", d, 8'h10);
        chk("R5 level raises", int'(int_out), 1);
        irq_in[4] = 1'b0; @(negedge clk);
        rd(0, d); chk("R5 level request follows", d, 8'h00);
        chk("R5 level drop", int'(int_out), 0);
        level_sel = 8'h00;

        // R12/R5: slave with global level mode
        do_reset();
        slave_mode = 1'b1;
        wr(0, 8'h19); wr(1, 8'h48); wr(1, 8'h02); wr(1, 8'h01); wr(1, 8'h00);
        irq_in[7] = 1'b1; @(negedge clk);
        chk("R12 slave raises", int'(int_out), 1);
        casc_sel_in = 3'd3;
        ack();
        chk("R12 wrong select no vector", int'(vec_vld), 0);
        wr(0, 8'h0B);
        rd(0, d); chk("R12 wrong select no ISR", d, 8'h00);
        casc_sel_in = 3'd2;
        ack();
        chk("R12 matching select vector", vec_out, 8'h4F);
        chk("R12 matching select valid", int'(vec_vld), 1);
        rd(0, d); chk("R12 ISR set", d, 8'h80);
        irq_in[7] = 1'b0; @(negedge clk);
        wr(0, 8'h0A);
        rd(0, d); chk("R5 global level follows", d, 8'h00);
        slave_mode = 1'b0;
        casc_sel_in = 3'd0;

        // R2: chain without mode word, then random edge traffic
        do_reset();
        wr(0, 8'h10); wr(1, 8'h20); wr(1, 8'h00);
        wr(1, 8'h5A);
        rd(1, d); chk("R2 third write is mask without mode word", d, 8'h5A);
        wr(1, 8'h00);
        irr_m = '0; imr_m = '0; isr_m = '0;
        for (int n = 0; n < 300; n++) begin
            r = $urandom % 6;
            if (r < 2) begin
                i = $urandom % 8;
                if (!irq_in[i]) irr_m[i] = 1'b1;
                irq_in[i] = ~irq_in[i];
                @(negedge clk);
            end else if (r == 2 || r == 3) begin
                if (exp_int(irr_m, imr_m, isr_m)) begin
                    w = lowest(irr_m & ~imr_m);
                    ack();
                    chk("R7 random vector", vec_out, 8'h20 | w);
                    isr_m[w] = 1'b1;
                    irr_m[w] = 1'b0;
                end else begin
                    ack();
                    chk("R8 random spurious vector", vec_out, 8'h27);
                end
            end else if (r == 4) begin
                wr(0, 8'h20);
                if (isr_m != 0) isr_m[lowest(isr_m)] = 1'b0;
            end else begin
                msk = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
                wr(1, msk);
                imr_m = msk;
            end
            chk("R6 random int_out", int'(int_out), int'(exp_int(irr_m, imr_m, isr_m)));
            rd(0, d); chk("R4 random IRR", d, irr_m);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule